// File: doc/BRIEF.md
# Packed Quadword Equality Compare Unit

This unit compares two 512-bit operands as eight packed 64-bit lanes and reports which lanes hold equal values. A mode input picks one of three result styles. Two styles write a vector result, a full lane of ones for a match and zeros for a mismatch. The first vector style keeps the old destination bits above the operation width. The second clears them. The third style writes one bit per lane into an 8-bit mask. The mask style can also apply a zeroing writemask and compare every lane against one broadcast scalar.

A request is presented with `in_valid` together with the operands, the old destination, the mode and width codes, the writemask controls and the broadcast qualifiers. The result is registered and appears one cycle later with `out_valid`. Both result outputs keep their values until the next accepted request. The unit has no flag outputs, so a compare changes no status.

Top module: `qeq_cmp_unit`

## Requirements
- R1: In both vector modes, each compared lane of `vec_out` is 64'hFFFF_FFFF_FFFF_FFFF when its two operand lanes are equal and zero when they differ. Lane k occupies bits [64k+63:64k].
- R2: Mode 0 (keep-upper) takes width code 0 (128 bits) only. Its first operand is `dst_old` and `src_a` has no effect. Lanes 0 and 1 are compared, and `vec_out[511:128]` equals `dst_old[511:128]`.
- R3: Mode 1 (zero-upper) with width code 0 (128 bits) compares lanes 0 and 1 of `src_a` and `src_b`. It clears `vec_out[511:128]`, and `dst_old` has no effect.
- R4: Mode 1 with width code 1 (256 bits) compares lanes 0 to 3 and clears `vec_out[511:256]`.
- R5: Mode 2 (mask) sets `mask_out[j]` when lane j of `src_a` equals lane j of `src_b`. Width codes 0, 1 and 2 make 2, 4 and 8 lanes active, and `vec_out` is zero in this mode.
- R6: In mask mode, every `mask_out` bit at or above the active lane count is zero.
- R7: In mask mode with `wm_en`=1, a lane whose `wmask` bit is 0 produces a 0 mask bit. With `wm_en`=0, `wmask` has no effect and every active lane is enabled.
- R8: In mask mode with both `bcast`=1 and `b_mem`=1, every lane compares against `src_b[63:0]`. If only `bcast` is set, lanes compare against their own `src_b` lane. In the vector modes `bcast` has no effect.
- R9: Some encodings are unused: mode 3, width code 3, mode 0 with any width code other than 0, and mode 1 with width code 2. For these, `vec_out` and `mask_out` are both zero while `out_valid` is still asserted.
- R10: `out_valid` equals `in_valid` delayed by one cycle. Outputs change only after an accepted request and hold while `in_valid` is low. The vector modes drive `mask_out` to zero.
- R11: After reset, `out_valid`, `vec_out` and `mask_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 0 keep-upper, 1 zero-upper, 2 mask, 3 unused |
| width | input | 2 | 0 128-bit, 1 256-bit, 2 512-bit, 3 unused |
| src_a | input | 512 | First operand (not used in mode 0) |
| src_b | input | 512 | Second operand |
| dst_old | input | 512 | Previous destination; first operand in mode 0 |
| wm_en | input | 1 | Writemask selected |
| wmask | input | 8 | Per-lane writemask |
| bcast | input | 1 | Broadcast qualifier |
| b_mem | input | 1 | Second operand comes from memory |
| out_valid | output | 1 | Result valid |
| vec_out | output | 512 | Vector result |
| mask_out | output | 8 | Mask result |

## Verification
The bench uses the default parameters: 64-bit lanes in a 512-bit register, which gives eight lanes and an 8-bit mask. With eight lanes, all three mask widths can be reached. Upper-lane clearing can therefore be checked at both 128 and 256 bits, and preservation of the old destination through lane 7. A mismatch placed in lane 2 and lane 6 separates the 2-, 4- and 8-lane results. A broadcast operand whose upper lanes differ from its low lane shows whether the scalar is actually used.

// File: rtl/qeq_cmp_unit.sv
module qeq_cmp_unit #(
  parameter int LANE_W = 64,
  parameter int VEC_W  = 512
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [1:0]                  mode,
  input  logic [1:0]                  width,
  input  logic [VEC_W-1:0]            src_a,
  input  logic [VEC_W-1:0]            src_b,
  input  logic [VEC_W-1:0]            dst_old,
  input  logic                        wm_en,
  input  logic [VEC_W/LANE_W-1:0]     wmask,
  input  logic                        bcast,
  input  logic                        b_mem,
  output logic                        out_valid,
  output logic [VEC_W-1:0]            vec_out,
  output logic [VEC_W/LANE_W-1:0]     mask_out
);
  localparam int LANES = VEC_W / LANE_W;
  localparam logic [1:0] M_KEEP = 2'd0, M_ZERO = 2'd1, M_MASK = 2'd2;
  localparam logic [1:0] W128 = 2'd0, W256 = 2'd1, W512 = 2'd2;

  function automatic logic [LANES-1:0] low_lanes(input int bits);
    for (int k = 0; k < LANES; k++) low_lanes[k] = (k < bits / LANE_W);
  endfunction

  logic             bc;
  logic [LANES-1:0] eq;
  logic [LANES-1:0] act;
  logic             ok;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic [LANES-1:0] mask_d, mask_q;

  assign bc = (mode == M_MASK) && bcast && b_mem;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l;
    assign a_l   = (mode == M_KEEP) ? dst_old[j*LANE_W +: LANE_W] : src_a[j*LANE_W +: LANE_W];
    assign b_l   = bc ? src_b[LANE_W-1:0] : src_b[j*LANE_W +: LANE_W];
    assign eq[j] = (a_l == b_l);
  end

  always_comb begin
    ok  = 1'b0;
    act = '0;
    case (mode)
      M_KEEP: if (width == W128) begin ok = 1'b1; act = low_lanes(128); end
      M_ZERO: begin
        if (width == W128) begin ok = 1'b1; act = low_lanes(128); end
        else if (width == W256) begin ok = 1'b1; act = low_lanes(256); end
      end
      M_MASK: begin
        if (width == W128) begin ok = 1'b1; act = low_lanes(128); end
        else if (width == W256) begin ok = 1'b1; act = low_lanes(256); end
        else if (width == W512) begin ok = 1'b1; act = low_lanes(512); end
      end
      default: ;
    endcase
  end

  always_comb begin
    vec_d  = '0;
    mask_d = '0;
    if (ok) begin
      if (mode == M_MASK) begin
        for (int k = 0; k < LANES; k++)
          mask_d[k] = act[k] & eq[k] & (~wm_en | wmask[k]);
      end else begin
        if (mode == M_KEEP) vec_d = dst_old;
        for (int k = 0; k < LANES; k++)
          if (act[k]) vec_d[k*LANE_W +: LANE_W] = {LANE_W{eq[k]}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      vec_q     <= '0;
      mask_q    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        vec_q  <= vec_d;
        mask_q <= mask_d;
      end
    end
  end

  assign vec_out  = vec_q;
  assign mask_out = mask_q;

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(vec_out) && $stable(mask_out)));

  // R2
  keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && mode == M_KEEP && width == W128)
      |-> vec_out[VEC_W-1:128] == $past(dst_old[VEC_W-1:128]));

  // R3
  zero_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && mode == M_ZERO) |-> vec_out[VEC_W-1:256] == '0);

  // R5
  mask_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && mode == M_MASK) |-> vec_out == '0);

  // R6
  mask_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid) |-> (mask_out & ~$past(act)) == '0);

  // R7
  wmask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && in_valid && mode == M_MASK && wm_en) |-> (mask_out & ~$past(wmask)) == '0);
endmodule

// File: tb/qeq_cmp_unit_tb.sv
module qeq_cmp_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   mode = '0, width = '0;
  logic [511:0] src_a = '0, src_b = '0, dst_old = '0;
  logic         wm_en = 1'b0;
  logic [7:0]   wmask = '0;
  logic         bcast = 1'b0, b_mem = 1'b0;
  logic         out_valid;
  logic [511:0] vec_out;
  logic [7:0]   mask_out;

  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qeq_cmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .width(width),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .wm_en(wm_en), .wmask(wmask),
    .bcast(bcast), .b_mem(b_mem), .out_valid(out_valid), .vec_out(vec_out),
    .mask_out(mask_out)
  );

  function automatic logic [511:0] pat(input logic [15:0] seed);
    for (int k = 0; k < 8; k++)
      pat[k*64 +: 64] = {seed, 8'(k), 8'h3C, 32'hA5C3_0F19 ^ {16'(k), seed}};
  endfunction

  function automatic logic [511:0] alter(input logic [511:0] v, input logic [7:0] diff);
    alter = v;
    for (int k = 0; k < 8; k++)
      if (diff[k]) alter[k*64 +: 64] = v[k*64 +: 64] ^ 64'h0000_0100_0000_0001;
  endfunction

  function automatic logic [511:0] lanes(input logic [7:0] ones);
    for (int k = 0; k < 8; k++) lanes[k*64 +: 64] = {64{ones[k]}};
  endfunction

  task automatic chk_v(input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s vec_out actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_m(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mask_out actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_b(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [1:0] w, input logic [511:0] a,
                       input logic [511:0] b, input logic [511:0] d, input logic we,
                       input logic [7:0] wm, input logic bc, input logic bmem);
    @(negedge clk);
    mode = m; width = w; src_a = a; src_b = b; dst_old = d;
    wm_en = we; wmask = wm; bcast = bc; b_mem = bmem; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_b("R10 out_valid after request", out_valid, 1'b1);
  endtask

  task automatic t_reset;
    chk_b("R11 out_valid in reset", out_valid, 1'b0);
    chk_v("R11 reset", vec_out, '0);
    chk_m("R11 reset", mask_out, '0);
  endtask

  task automatic t_keep;
    logic [511:0] d = pat(16'h1111);
    logic [511:0] b = alter(d, 8'b0000_0010);
    logic [511:0] e = d;
    e[127:0] = lanes(8'b0000_0001) & {384'b0, {128{1'b1}}};
    issue(2'd0, 2'd0, b, b, d, 1'b0, 8'h00, 1'b1, 1'b1);
    chk_v("R2 R1 R8 keep-upper 128", vec_out, e);
    chk_m("R10 vector mode mask zero", mask_out, 8'h00);
  endtask

  task automatic t_zero128;
    logic [511:0] a = pat(16'h2222);
    issue(2'd1, 2'd0, a, alter(a, 8'b1111_1110), '1, 1'b0, 8'h00, 1'b1, 1'b1);
    chk_v("R3 R1 R8 zero-upper 128", vec_out, lanes(8'b0000_0001));
  endtask

  task automatic t_zero256;
    logic [511:0] a = pat(16'h3333);
    issue(2'd1, 2'd1, a, alter(a, 8'b0000_0101), '1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_v("R4 R1 zero-upper 256", vec_out, lanes(8'b0000_1010));
  endtask

  task automatic t_mask_widths;
    logic [511:0] a = pat(16'h4444);
    logic [511:0] b = alter(a, 8'b0100_0100);
    issue(2'd2, 2'd0, a, b, '1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_m("R5 R6 mask 128", mask_out, 8'h03);
    chk_v("R5 mask vec zero", vec_out, '0);
    issue(2'd2, 2'd1, a, b, '1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_m("R5 R6 mask 256", mask_out, 8'h0B);
    issue(2'd2, 2'd2, a, b, '1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_m("R5 mask 512", mask_out, 8'hBB);
  endtask

  task automatic t_wmask;
    logic [511:0] a = pat(16'h5555);
    issue(2'd2, 2'd2, a, a, '0, 1'b1, 8'h5A, 1'b0, 1'b0);
    chk_m("R7 writemask zeroing", mask_out, 8'h5A);
    issue(2'd2, 2'd2, a, a, '0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_m("R7 writemask off", mask_out, 8'hFF);
  endtask

  task automatic t_bcast;
    logic [511:0] a, b;
    for (int k = 0; k < 8; k++) a[k*64 +: 64] = 64'h0123_4567_89AB_CDEF;
    b = alter(a, 8'b1111_1110);
    issue(2'd2, 2'd2, a, b, '0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk_m("R8 broadcast from memory", mask_out, 8'hFF);
    issue(2'd2, 2'd2, a, b, '0, 1'b0, 8'h00, 1'b1, 1'b0);
    chk_m("R8 broadcast without memory", mask_out, 8'h01);
    issue(2'd1, 2'd1, a, b, '0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk_v("R8 broadcast ignored in vector mode", vec_out, lanes(8'b0000_0001));
  endtask

  task automatic t_unused;
    logic [511:0] a = pat(16'h6666);
    issue(2'd3, 2'd0, a, a, '1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_v("R9 mode 3 vec", vec_out, '0);
    chk_m("R9 mode 3 mask", mask_out, 8'h00);
    issue(2'd0, 2'd1, a, a, '1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_v("R9 keep with width 1", vec_out, '0);
    issue(2'd1, 2'd2, a, a, '1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_v("R9 zero-upper with width 2", vec_out, '0);
    issue(2'd2, 2'd3, a, a, '1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_m("R9 mask width 3", mask_out, 8'h00);
  endtask

  task automatic t_hold;
    logic [511:0] a = pat(16'h7777);
    issue(2'd2, 2'd2, a, alter(a, 8'h81), '0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_m("R10 mask before idle", mask_out, 8'h7E);
    @(negedge clk);
    mode = 2'd1; width = 2'd1; src_b = a; src_a = a;
    repeat (3) @(negedge clk);
    chk_b("R10 out_valid low when idle", out_valid, 1'b0);
    chk_m("R10 mask holds", mask_out, 8'h7E);
    chk_v("R10 vec holds", vec_out, '0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_keep();
    t_zero128();
    t_zero256();
    t_mask_widths();
    t_wmask();
    t_bcast();
    t_unused();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule